// File: doc/BRIEF.md
# Four-Region Data Memory Protection Unit

This block screens every data-side load or store that a processor sends towards the system bus. Each request carries an address, a read/write flag, a privilege flag and a flag that marks accesses aimed at the bridge's own internal special registers. The block compares the address against four programmable protection windows. Each window has an address comparator, which matches on the aligned power-of-two range, and an attribute check. The lowest-numbered enabled window that matches supplies the attributes. An address that falls in no enabled window is judged by a separately programmed global attribute set.

The pass/violation decision is combinational on the request, so the bridge can forward or block the access in the same cycle. A violation is also registered. One cycle later an exception request goes to the processor, together with the offending address, its direction and the number of the window that caused it. Software programs the windows and the global set through a simple single-cycle register write port.

Top module: `dprot_unit`

## Requirements
- R1: After hard reset (`rstN` low) every window is disabled and the global attributes are all clear. Every system-bus access then passes and `excReq` is low.
- R2: Writing `cfgSel` = 0..3 loads that window. The `cfgData` fields are: bit 0 enable, bit 1 read-only, bit 2 supervisor-only, bit 3 no-access, bits 8:4 size exponent, bits 31:12 base. The window covers 2^size bytes, and any exponent below 12 counts as 12 (4 KB).
- R3: Base bits below the window size are ignored, so the window always sits on an address aligned to its size.
- R4: A write that hits a read-only window is a violation. A read of the same window passes.
- R5: A user-mode access (`reqUser`=1) that hits a supervisor-only window is a violation. A supervisor access passes.
- R6: Any access that hits a no-access window is a violation.
- R7: When enabled windows overlap, the lowest-numbered matching window alone decides the outcome.
- R8: A disabled window never matches.
- R9: An address outside every enabled window is judged by the global attributes. These are written with `cfgSel` = 4, using bits 1 (read-only), 2 (supervisor-only) and 3 (no-access).
- R10: An access with `reqInternal`=1 is never flagged, whatever the attributes.
- R11: A violating valid request raises `excReq` for exactly the following cycle. In that cycle `excAddr` and `excWrite` hold the request's address and direction, and `excRegion` holds the deciding window (0..3, or 4 for the global set).
- R12: While `reqValid` is low, `accPass` and `accViolate` are both low and no exception is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset, asynchronous |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Configuration target: 0..3 window, 4 global |
| cfgData | input | 32 | Configuration write data |
| reqValid | input | 1 | Data access request present |
| reqAddr | input | 32 | Access address |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqUser | input | 1 | 1 = user mode, 0 = supervisor |
| reqInternal | input | 1 | Access targets the bridge's internal registers |
| accPass | output | 1 | Access may be forwarded (combinational) |
| accViolate | output | 1 | Access is blocked (combinational) |
| excReq | output | 1 | Exception request, one cycle after a violation |
| excAddr | output | 32 | Address of the violating access |
| excWrite | output | 1 | Direction of the violating access |
| excRegion | output | 3 | Deciding window, 4 = global |

## Verification
The bench probes the edges of each window: the last word inside it and the first word past it. A comparator off by one bit would let the neighbour through or flag it. It programs a 64 KB window from a base that is not aligned, and a window whose size exponent is below the 4 KB floor. These catch a design that compares the raw base, or that builds a window only a few bytes long. Overlapping windows, and then disabling the lower one, expose a priority encoder that picks the highest index or keeps matching on a stale enable. Global attributes that differ from a window's show whether a hit wrongly falls through to the global set. Internal and idle requests under a no-access global set must stay silent, or the design would raise spurious exceptions.

// File: rtl/dprot_pkg.sv
package dprot_pkg;

  // Field positions inside a configuration word
  localparam int EnBit    = 0;
  localparam int RoBit    = 1;
  localparam int SupBit   = 2;
  localparam int NaBit    = 3;
  localparam int SizeLsb  = 4;
  localparam int SizeW    = 5;
  localparam int SelMaxW  = 4;

  typedef struct packed {
    logic noAccess;
    logic supOnly;
    logic readOnly;
  } protAttr_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic               regionWe;
    logic [SelMaxW-1:0] regionIdx;
    logic               globalWe;
    logic               capture;
  } dpStrobe_t;

endpackage

// File: rtl/dprot_region.sv
module dprot_region
  import dprot_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              hit,
  output protAttr_t         attr
);

  localparam int LogW = $clog2(ADDR_W + 1);

  logic                     enable;
  logic [ADDR_W-1:MIN_LOG2] base;
  logic [SizeW-1:0]         sizeExp;
  logic [LogW-1:0]          effLog2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      attr    <= '0;
      base    <= '0;
      sizeExp <= '0;
    end else if (we) begin
      enable        <= wrData[EnBit];
      attr.readOnly <= wrData[RoBit];
      attr.supOnly  <= wrData[SupBit];
      attr.noAccess <= wrData[NaBit];
      sizeExp       <= wrData[SizeLsb +: SizeW];
      base          <= wrData[ADDR_W-1:MIN_LOG2];
    end
  end

  // Clamp the size exponent into [MIN_LOG2, ADDR_W]
  always_comb begin
    if (int'(sizeExp) < MIN_LOG2)      effLog2 = LogW'(MIN_LOG2);
    else if (int'(sizeExp) > ADDR_W)   effLog2 = LogW'(ADDR_W);
    else                               effLog2 = LogW'(sizeExp);
  end

  // Compare only the address bits above the window size
  always_comb begin
    hit = enable;
    for (int i = MIN_LOG2; i < ADDR_W; i++) begin
      if (i >= int'(effLog2) && reqAddr[i] != base[i]) hit = 1'b0;
    end
  end

endmodule

// File: rtl/dprot_datapath.sv
module dprot_datapath
  import dprot_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 4,
  parameter int MIN_LOG2    = 12,
  parameter int SEL_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  output logic              rawViol,
  output logic [ADDR_W-1:0] excAddr,
  output logic              excWrite,
  output logic [SEL_W-1:0]  excRegion
);

  logic      [NUM_REGIONS-1:0] regHit;
  protAttr_t                   regAttr [NUM_REGIONS];
  protAttr_t                   globalAttr;
  protAttr_t                   selAttr;
  logic      [SEL_W-1:0]       selIdx;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    logic regWe;
    assign regWe = strobe.regionWe && (int'(strobe.regionIdx) == g);
    dprot_region #(
      .ADDR_W  (ADDR_W),
      .MIN_LOG2(MIN_LOG2)
    ) uRegion (
      .clk    (clk),
      .rstN   (rstN),
      .we     (regWe),
      .wrData (cfgData),
      .reqAddr(reqAddr),
      .hit    (regHit[g]),
      .attr   (regAttr[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalAttr <= '0;
    end else if (strobe.globalWe) begin
      globalAttr.readOnly <= cfgData[RoBit];
      globalAttr.supOnly  <= cfgData[SupBit];
      globalAttr.noAccess <= cfgData[NaBit];
    end
  end

  // Lowest index wins: scan from the top so lower hits overwrite
  always_comb begin
    selAttr = globalAttr;
    selIdx  = SEL_W'(NUM_REGIONS);
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (regHit[i]) begin
        selAttr = regAttr[i];
        selIdx  = SEL_W'(i);
      end
    end
  end

  assign rawViol = selAttr.noAccess
                 | (selAttr.readOnly & reqWrite)
                 | (selAttr.supOnly  & reqUser);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excAddr   <= '0;
      excWrite  <= 1'b0;
      excRegion <= '0;
    end else if (strobe.capture) begin
      excAddr   <= reqAddr;
      excWrite  <= reqWrite;
      excRegion <= selIdx;
    end
  end

endmodule

// File: rtl/dprot_ctrl.sv
module dprot_ctrl
  import dprot_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int SEL_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             reqValid,
  input  logic             reqInternal,
  input  logic             rawViol,
  output dpStrobe_t        strobe,
  output logic             accPass,
  output logic             accViolate,
  output logic             excReq
);

  logic checked;

  // Internal register accesses are exempt from the check
  assign checked    = reqValid & ~reqInternal;
  assign accViolate = checked & rawViol;
  assign accPass    = reqValid & ~accViolate;

  always_comb begin
    strobe.regionWe  = cfgWe && (int'(cfgSel) < NUM_REGIONS);
    strobe.regionIdx = SelMaxW'(cfgSel);
    strobe.globalWe  = cfgWe && (int'(cfgSel) == NUM_REGIONS);
    strobe.capture   = accViolate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) excReq <= 1'b0;
    else       excReq <= accViolate;
  end

endmodule

// File: rtl/dprot_unit.sv
module dprot_unit
  import dprot_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 4,
  parameter int MIN_LOG2    = 12,
  parameter int SEL_W       = $clog2(NUM_REGIONS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              reqInternal,
  output logic              accPass,
  output logic              accViolate,
  output logic              excReq,
  output logic [ADDR_W-1:0] excAddr,
  output logic              excWrite,
  output logic [SEL_W-1:0]  excRegion
);

  dpStrobe_t strobe;
  logic      rawViol;

  dprot_ctrl #(
    .NUM_REGIONS(NUM_REGIONS),
    .SEL_W      (SEL_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgSel     (cfgSel),
    .reqValid   (reqValid),
    .reqInternal(reqInternal),
    .rawViol    (rawViol),
    .strobe     (strobe),
    .accPass    (accPass),
    .accViolate (accViolate),
    .excReq     (excReq)
  );

  dprot_datapath #(
    .ADDR_W     (ADDR_W),
    .NUM_REGIONS(NUM_REGIONS),
    .MIN_LOG2   (MIN_LOG2),
    .SEL_W      (SEL_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgData  (cfgData),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqUser  (reqUser),
    .rawViol  (rawViol),
    .excAddr  (excAddr),
    .excWrite (excWrite),
    .excRegion(excRegion)
  );

endmodule

// File: rtl/dprot_unit_chk.sv
module dprot_unit_chk #(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 4,
  parameter int SEL_W       = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqWrite,
  input logic              reqInternal,
  input logic              accPass,
  input logic              accViolate,
  input logic              excReq,
  input logic [ADDR_W-1:0] excAddr,
  input logic              excWrite,
  input logic [SEL_W-1:0]  excRegion
);

  // R12: idle requests produce no decision
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!accPass && !accViolate));

  // R10: internal register accesses always pass
  a_r10_internal_exempt: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqInternal) |-> accPass);

  // R11: a violation is followed by an exception carrying the access
  a_r11_exc_follows: assert property (@(posedge clk) disable iff (!rstN)
    accViolate |=> (excReq && excAddr == $past(reqAddr) && excWrite == $past(reqWrite)));

  // R11: no exception without a preceding violation
  a_r11_exc_cause: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> $past(accViolate));

  // R11: reported window index stays in range
  a_r11_region_range: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (int'(excRegion) <= NUM_REGIONS));

  // R1: pass and violation never together
  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(accPass && accViolate));

endmodule

bind dprot_unit dprot_unit_chk #(
  .ADDR_W     (ADDR_W),
  .NUM_REGIONS(NUM_REGIONS),
  .SEL_W      (SEL_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqAddr    (reqAddr),
  .reqWrite   (reqWrite),
  .reqInternal(reqInternal),
  .accPass    (accPass),
  .accViolate (accViolate),
  .excReq     (excReq),
  .excAddr    (excAddr),
  .excWrite   (excWrite),
  .excRegion  (excRegion)
);

// File: tb/dprot_unit_test.sv
module dprot_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        reqInternal = 1'b0;
  logic        accPass, accViolate, excReq, excWrite;
  logic [31:0] excAddr;
  logic [2:0]  excRegion;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dprot_unit uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqUser(reqUser),
    .reqInternal(reqInternal), .accPass(accPass), .accViolate(accViolate),
    .excReq(excReq), .excAddr(excAddr), .excWrite(excWrite), .excRegion(excRegion)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkRegion(input logic [31:0] base, input int sizeExp,
                                           input bit na, input bit sup, input bit ro,
                                           input bit en);
    return {base[31:12], 3'b000, 5'(sizeExp), na, sup, ro, en};
  endfunction

  // Called in the low clock phase; returns in the low phase
  task automatic cfgWrite(input logic [2:0] sel, input logic [31:0] data);
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    @(posedge clk); @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic probe(input bit valid, input logic [31:0] addr, input bit wr,
                       input bit user, input bit intl, input bit expViol,
                       input logic [2:0] expRegion, input string tag);
    reqValid = valid; reqAddr = addr; reqWrite = wr; reqUser = user; reqInternal = intl;
    #1;
    check(accViolate == expViol, {tag, " accViolate"}, 32'(accViolate), 32'(expViol));
    check(accPass == (valid && !expViol), {tag, " accPass"}, 32'(accPass),
          32'(valid && !expViol));
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    #1;
    check(excReq == expViol, {tag, " excReq"}, 32'(excReq), 32'(expViol));
    if (expViol) begin
      check(excAddr == addr, {tag, " excAddr"}, excAddr, addr);
      check(excWrite == wr, {tag, " excWrite"}, 32'(excWrite), 32'(wr));
      check(excRegion == expRegion, {tag, " excRegion"}, 32'(excRegion), 32'(expRegion));
    end
  endtask

  task automatic t_reset;
    #1;
    check(excReq == 1'b0, "R1 reset excReq", 32'(excReq), 0);
    check(accPass == 1'b0, "R12 reset idle accPass", 32'(accPass), 0);
    probe(1, 32'h0000_1000, 1, 1, 0, 0, 0, "R1 user write after reset");
    probe(1, 32'hFFFF_F000, 0, 1, 0, 0, 0, "R1 user read top after reset");
  endtask

  task automatic t_readOnly;
    cfgWrite(0, mkRegion(32'h0001_0000, 16, 0, 0, 1, 1));
    probe(1, 32'h0001_8000, 1, 0, 0, 1, 0, "R4 write to read-only");
    probe(1, 32'h0001_8000, 0, 0, 0, 0, 0, "R4 read of read-only");
    probe(1, 32'h0001_FFFC, 1, 0, 0, 1, 0, "R2 last word of window");
    probe(1, 32'h0002_0000, 1, 0, 0, 0, 0, "R2 first word past window");
    probe(1, 32'h0000_FFFC, 1, 0, 0, 0, 0, "R2 word below window");
  endtask

  task automatic t_minSize;
    cfgWrite(1, mkRegion(32'h0003_0000, 3, 1, 0, 0, 1));
    probe(1, 32'h0003_0FFC, 0, 0, 0, 1, 1, "R6 no-access inside 4KB floor");
    probe(1, 32'h0003_1000, 0, 0, 0, 0, 0, "R2 past 4KB floor");
  endtask

  task automatic t_align;
    cfgWrite(2, mkRegion(32'h0005_3000, 16, 0, 1, 0, 1));
    probe(1, 32'h0005_0010, 0, 1, 0, 1, 2, "R3 R5 user below raw base");
    probe(1, 32'h0005_FFF0, 1, 1, 0, 1, 2, "R5 user write high in window");
    probe(1, 32'h0005_0010, 0, 0, 0, 0, 0, "R5 supervisor read");
  endtask

  task automatic t_overlap;
    cfgWrite(3, mkRegion(32'h0001_0000, 20, 1, 0, 0, 1));
    probe(1, 32'h0001_4000, 0, 0, 0, 0, 0, "R7 lower window wins");
    probe(1, 32'h0008_0000, 0, 0, 0, 1, 3, "R7 only window 3 hits");
    probe(1, 32'h0003_0000, 0, 0, 0, 1, 1, "R7 window 1 over window 3");
  endtask

  task automatic t_disable;
    cfgWrite(0, mkRegion(32'h0001_0000, 16, 0, 0, 1, 0));
    probe(1, 32'h0001_4000, 0, 0, 0, 1, 3, "R8 disabled window 0 skipped");
    cfgWrite(3, mkRegion(32'h0001_0000, 20, 1, 0, 0, 0));
    probe(1, 32'h0001_4000, 1, 0, 0, 0, 0, "R8 all covering windows disabled");
  endtask

  task automatic t_global;
    cfgWrite(4, 32'h0000_0006);
    probe(1, 32'h0090_0000, 0, 1, 0, 1, 4, "R9 global supervisor-only");
    probe(1, 32'h0090_0000, 1, 0, 0, 1, 4, "R9 global read-only");
    probe(1, 32'h0090_0000, 0, 0, 0, 0, 0, "R9 global supervisor read");
    probe(1, 32'h0005_0010, 1, 0, 0, 0, 0, "R9 window overrides global");
  endtask

  task automatic t_internal;
    cfgWrite(4, 32'h0000_0008);
    probe(1, 32'h0090_0000, 1, 1, 1, 0, 0, "R10 internal under global no-access");
    probe(1, 32'h0003_0000, 1, 1, 1, 0, 0, "R10 internal in no-access window");
    probe(1, 32'h0090_0000, 0, 0, 0, 1, 4, "R6 global no-access");
  endtask

  task automatic t_idle;
    probe(0, 32'h0090_0000, 1, 1, 0, 0, 0, "R12 idle with violating address");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_readOnly();
    t_minSize();
    t_align();
    t_overlap();
    t_disable();
    t_global();
    t_internal();
    t_idle();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule